// File: doc/BRIEF.md
# Always-On Seconds Clock with Compare Alarm

This peripheral keeps wall-clock time as a 32-bit unsigned seconds count plus a sub-second tick counter. Both run on a slow, always-on clock that is unrelated to the bus clock. A compare register raises an alarm flag when the seconds count reaches it. The flag drives an interrupt line and a wakeup line, and each line has its own enable.

Before time can advance, the block must pass through a power-up lifecycle. It starts in an initial state. A control command moves it to a not-yet-valid state. A second command moves it to the valid state, but that command is honoured only after a fixed key value has been written into the glitch-key register. Software writes arrive from the bus clock and are carried into the slow domain, where they take effect. Reads return the live slow-domain state through a registered read port. Software polls the sub-second register to see time advance.

Register offsets in bytes: 0x00 seconds, 0x04 sub-second, 0x08 alarm compare, 0x10 control, 0x14 status, 0x18 glitch key.

Top module: `rtc_lp`

## Requirements
- R1: Seconds (0x00) and alarm (0x08) read back the last value written. Control (0x10) reads back only bits 3, 4, 7, 11, 14 and 15 of the written value, with every other bit zero. The key register (0x18) reads as zero, and sub-second (0x04) reads zero-extended.
- R2: After reset the lifecycle is in the initial state. A control write with bit 15 set moves it to the not-valid state, and status bit 15 then reads 1.
- R3: In the not-valid state, a control write with bit 14 set moves the lifecycle to the valid state only if the key register holds 0x41736166. Status bit 14 then reads 1. With any other key the request is ignored and status bit 14 stays 0.
- R4: The counters hold their values unless the lifecycle is valid and control bit 3 is 1.
- R5: While counting, the sub-second counter advances by one on each slow-clock edge and wraps from 2^SUB_W-1 to 0. At that wrap the seconds count increments, rolling over from 0xFFFFFFFF to 0.
- R6: A write to the seconds register loads the count and clears the sub-second counter.
- R7: Status bit 3 (alarm flag) is set in the valid state when the seconds count becomes equal to the alarm register. This happens either through counting or through a write to either register.
- R8: Output irq is 1 while the alarm flag and control bit 7 are both 1. Output wake is 1 while the alarm flag and control bit 4 are both 1.
- R9: Writing ones to status clears the alarm flag (write-one-to-clear). Status bits 15 and 14 are unaffected by such writes.
- R10: A bus write takes effect in the slow domain within three slow-clock edges. A further write issued while an earlier one is still crossing is dropped.
- R11: After reset all status bits read 0, the seconds and sub-second counts read 0, and irq and wake are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain; also resynchronised into the slow domain |
| sclk | input | 1 | Slow always-on counting clock |
| bus_sel | input | 1 | Access strobe, one bus cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq | output | 1 | Alarm interrupt |
| wake | output | 1 | Alarm wakeup request |

## Verification
On every slow-clock edge the assertions check the following: the counters stay frozen outside the enabled valid state, the sub-second wrap carries exactly one second, the valid state is never entered without the key and is never left, and the flag rises only from the valid state. In the bus domain they check that a write arriving during a crossing leaves the held data untouched. The bench scenarios show the rest. These are the register map and control mask, the lifecycle sequence with a wrong and a right key, the counting rate across the clock ratio, the 32-bit rollover, the irq and wake gating, write-one-to-clear, and a randomised sequence of compare and seconds writes against a model of when the alarm should set.

// File: rtl/rtc_lp_pkg.sv
package rtc_lp_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_SEC = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_SUB = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_ALM = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CTL = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_STS = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_KEY = 5'h18;

  // control bit positions
  localparam int C_RUN      = 3;
  localparam int C_WAKE_EN  = 4;
  localparam int C_IRQ_EN   = 7;
  localparam int C_OPEN_ACC = 11;
  localparam int C_GO_VALID = 14;
  localparam int C_GO_NV    = 15;
  // status bit positions
  localparam int S_ALARM    = 3;
  localparam int S_VALID    = 14;
  localparam int S_NV       = 15;

  localparam logic [REG_W-1:0] CTL_MASK =
    (REG_W'(1) << C_RUN) | (REG_W'(1) << C_WAKE_EN) | (REG_W'(1) << C_IRQ_EN) |
    (REG_W'(1) << C_OPEN_ACC) | (REG_W'(1) << C_GO_VALID) | (REG_W'(1) << C_GO_NV);

  localparam logic [REG_W-1:0] GLITCH_KEY = 32'h4173_6166;

  typedef enum logic [1:0] {LC_INIT, LC_NOTVALID, LC_VALID} lc_t;
endpackage

// File: rtl/rtc_lp_wrx.sv
module rtc_lp_wrx
  import rtc_lp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              sclk,
  input  logic              srst,
  output logic              s_stb,
  output logic [ADDR_W-1:0] s_addr,
  output logic [REG_W-1:0]  s_data
);
  logic req_t, ack_b1, ack_b2;
  logic rq1, rq2, rq3, ack_t;
  logic [ADDR_W-1:0] hold_addr;
  logic [REG_W-1:0]  hold_data;
  logic pend, take;

  assign pend = req_t ^ ack_b2;
  assign take = bus_wr & ~pend;

  // bus side: capture one write, toggle request, wait for the echo
  always_ff @(posedge clk) begin
    if (rst) begin
      req_t     <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
      ack_b1    <= 1'b0;
      ack_b2    <= 1'b0;
    end else begin
      ack_b1 <= ack_t;
      ack_b2 <= ack_b1;
      if (take) begin
        req_t     <= ~req_t;
        hold_addr <= bus_addr;
        hold_data <= bus_wdata;
      end
    end
  end

  // slow side: two-flop sync plus edge detect
  always_ff @(posedge sclk) begin
    if (srst) begin
      rq1 <= 1'b0; rq2 <= 1'b0; rq3 <= 1'b0; ack_t <= 1'b0;
    end else begin
      rq1   <= req_t;
      rq2   <= rq1;
      rq3   <= rq2;
      ack_t <= rq3;
    end
  end

  assign s_stb  = rq2 ^ rq3;
  assign s_addr = hold_addr;
  assign s_data = hold_data;

  // R10: a write arriving mid-crossing must not disturb the held word
  assert_drop_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && pend) |=> $stable(hold_data));
endmodule

// File: rtl/rtc_lp_core.sv
module rtc_lp_core
  import rtc_lp_pkg::*;
#(
  parameter int SUB_W = 15
) (
  input  logic              sclk,
  input  logic              srst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  sec_q,
  output logic [SUB_W-1:0]  sub_q,
  output logic [REG_W-1:0]  alarm_q,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [REG_W-1:0]  status,
  output logic              irq_q,
  output logic              wake_q
);
  lc_t             lc;
  logic [REG_W-1:0] key_q;
  logic            flag_q, match_prev, match_now, run;
  logic            w_sec, w_alm, w_ctl, w_sts, w_key, sub_top;

  assign w_sec     = wr_stb && (wr_addr == OFS_SEC);
  assign w_alm     = wr_stb && (wr_addr == OFS_ALM);
  assign w_ctl     = wr_stb && (wr_addr == OFS_CTL);
  assign w_sts     = wr_stb && (wr_addr == OFS_STS);
  assign w_key     = wr_stb && (wr_addr == OFS_KEY);
  assign run       = (lc == LC_VALID) && ctrl_q[C_RUN];
  assign sub_top   = &sub_q;
  assign match_now = (sec_q == alarm_q);

  always_ff @(posedge sclk) begin
    if (srst) begin
      lc <= LC_INIT;
      sec_q <= '0; sub_q <= '0; alarm_q <= '0; ctrl_q <= '0; key_q <= '0;
      flag_q <= 1'b0; match_prev <= 1'b1; irq_q <= 1'b0; wake_q <= 1'b0;
    end else begin
      match_prev <= match_now;
      if (w_sec) begin
        sec_q <= wr_data;
        sub_q <= '0;
      end else if (run) begin
        sub_q <= sub_q + SUB_W'(1);
        if (sub_top) sec_q <= sec_q + REG_W'(1);
      end
      if (w_alm) alarm_q <= wr_data;
      if (w_ctl) ctrl_q  <= wr_data & CTL_MASK;
      if (w_key) key_q   <= wr_data;
      case (lc)
        LC_INIT:     if (w_ctl && wr_data[C_GO_NV]) lc <= LC_NOTVALID;
        LC_NOTVALID: if (w_ctl && wr_data[C_GO_VALID] && key_q == GLITCH_KEY) lc <= LC_VALID;
        default:     lc <= lc;
      endcase
      if (match_now && !match_prev && lc == LC_VALID) flag_q <= 1'b1;
      else if (w_sts && wr_data[S_ALARM])                flag_q <= 1'b0;
      irq_q  <= flag_q & ctrl_q[C_IRQ_EN];
      wake_q <= flag_q & ctrl_q[C_WAKE_EN];
    end
  end

  always_comb begin
    status          = '0;
    status[S_ALARM] = flag_q;
    status[S_VALID] = (lc == LC_VALID);
    status[S_NV]    = (lc != LC_INIT);
  end

  assert_frozen_R4: assert property (@(posedge sclk) disable iff (srst)
    (!run && !w_sec) |=> $stable(sub_q) && $stable(sec_q));
  assert_wrap_carry_R5: assert property (@(posedge sclk) disable iff (srst)
    (run && sub_top && !w_sec) |=> (sub_q == '0) && (sec_q == $past(sec_q) + REG_W'(1)));
  assert_key_gate_R3: assert property (@(posedge sclk) disable iff (srst)
    (lc == LC_NOTVALID && key_q != GLITCH_KEY) |=> (lc != LC_VALID));
  assert_valid_sticky_R2: assert property (@(posedge sclk) disable iff (srst)
    (lc == LC_VALID) |=> (lc == LC_VALID));
  assert_flag_valid_R7: assert property (@(posedge sclk) disable iff (srst)
    $rose(flag_q) |-> $past(lc == LC_VALID));
  assert_irq_gate_R8: assert property (@(posedge sclk) disable iff (srst)
    (irq_q || wake_q) |-> $past(flag_q));
endmodule

// File: rtl/rtc_lp.sv
module rtc_lp
  import rtc_lp_pkg::*;
#(
  parameter int SUB_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              wake
);
  logic srst_m, srst;
  logic              s_stb;
  logic [ADDR_W-1:0] s_addr;
  logic [REG_W-1:0]  s_data;
  logic [REG_W-1:0]  sec_q, alarm_q, ctrl_q, status;
  logic [SUB_W-1:0]  sub_q;

  always_ff @(posedge sclk) begin
    srst_m <= rst;
    srst   <= srst_m;
  end

  rtc_lp_wrx u_wrx (
    .clk(clk), .rst(rst), .bus_wr(bus_sel & bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .sclk(sclk), .srst(srst),
    .s_stb(s_stb), .s_addr(s_addr), .s_data(s_data)
  );

  rtc_lp_core #(.SUB_W(SUB_W)) u_core (
    .sclk(sclk), .srst(srst), .wr_stb(s_stb), .wr_addr(s_addr), .wr_data(s_data),
    .sec_q(sec_q), .sub_q(sub_q), .alarm_q(alarm_q), .ctrl_q(ctrl_q),
    .status(status), .irq_q(irq), .wake_q(wake)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_sel && !bus_we) begin
      case (bus_addr)
        OFS_SEC: bus_rdata <= sec_q;
        OFS_SUB: bus_rdata <= REG_W'(sub_q);
        OFS_ALM: bus_rdata <= alarm_q;
        OFS_CTL: bus_rdata <= ctrl_q;
        OFS_STS: bus_rdata <= status;
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: tb/tb_rtc_lp.sv
module tb_rtc_lp;
  localparam int SUB_W = 4;
  localparam int TPS   = 1 << SUB_W;
  localparam logic [31:0] KEY = 32'h4173_6166;

  logic clk = 1'b0, sclk = 1'b0, rst = 1'b1;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, wake;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2  clk  = ~clk;   // 250 MHz
  always #15 sclk = ~sclk;  // 30 ns slow clock, ratio 7.5

  rtc_lp #(.SUB_W(SUB_W)) dut (
    .clk(clk), .rst(rst), .sclk(sclk), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wake(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input int gap = 60);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  function automatic bit flag_model(input int os, input int oa, input int a, input int s);
    return ((os == a) && (os != oa)) || ((s == a) && (os != a));
  endfunction

  initial begin
    repeat (1500000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, s2;
    int cur_s, cur_a;
    void'($urandom(32'd11));
    repeat (40) @(negedge clk);
    rst = 0;
    repeat (20) @(negedge clk);

    // R11 reset state
    rd(5'h14, v); chk("R11 status", v, 32'h0);
    rd(5'h00, v); chk("R11 seconds", v, 32'h0);
    rd(5'h04, v); chk("R11 subsec", v, 32'h0);
    chk("R11 irq", {31'b0, irq}, 32'h0);
    chk("R11 wake", {31'b0, wake}, 32'h0);

    // R1 alarm readback, key reads zero
    wr(5'h08, 32'hFFFF_0000);
    rd(5'h08, v); chk("R1 alarm readback", v, 32'hFFFF_0000);

    // R4 frozen in initial state even with run bit
    wr(5'h10, 32'h0000_0008, 120);
    rd(5'h04, v); chk("R4 frozen in init", v, 32'h0);

    // R2 init exit
    wr(5'h10, 32'h0000_8808);
    rd(5'h14, v); chk("R2 init exit status", v, 32'h0000_8000);
    repeat (80) @(negedge clk);
    rd(5'h04, v); chk("R4 frozen in not-valid", v, 32'h0);

    // R3 wrong key
    wr(5'h18, 32'h1234_5678);
    rd(5'h18, v); chk("R1 key reads zero", v, 32'h0);
    wr(5'h10, 32'h0000_C808);
    rd(5'h14, v); chk("R3 wrong key ignored", v, 32'h0000_8000);

    // R3 right key, then stop counting
    wr(5'h18, KEY);
    wr(5'h10, 32'h0000_C808);
    rd(5'h14, v); chk("R3 valid with key", v, 32'h0000_C000);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, v); chk("R1 control mask", v, 32'h0000_C898);
    wr(5'h10, 32'h0000_C800);

    // R6 seconds load clears sub-second while running
    wr(5'h10, 32'h0000_C808);
    wr(5'h00, 32'h1234_5678, 60);
    wr(5'h10, 32'h0000_C800);
    rd(5'h00, v); chk("R6 seconds loaded", v, 32'h1234_5678);
    rd(5'h04, v); chk_rng("R6 sub restarted from zero", int'(v), 6, 10);
    wr(5'h00, 32'h0000_0040);
    rd(5'h04, v); chk("R6 sub cleared", v, 32'h0);

    // R5 counting rate and wrap
    wr(5'h00, 32'h0);
    wr(5'h10, 32'h0000_C808, 300);
    wr(5'h10, 32'h0000_C800);
    rd(5'h00, v); rd(5'h04, s2);
    chk_rng("R5 elapsed ticks", int'(v) * TPS + int'(s2), 38, 42);
    chk_rng("R5 seconds carried", int'(v), 2, 2);

    // R5 32-bit rollover
    wr(5'h00, 32'hFFFF_FFFF);
    wr(5'h10, 32'h0000_C808, 180);
    wr(5'h10, 32'h0000_C800);
    rd(5'h00, v); chk("R5 seconds rollover", v, 32'h0);

    // R10 back-to-back write dropped
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = 5'h08; bus_wdata = 32'h1111_1111;
    @(negedge clk); bus_wdata = 32'h2222_2222;
    @(negedge clk); bus_sel = 0; bus_we = 0;
    repeat (60) @(negedge clk);
    rd(5'h08, v); chk("R10 second write dropped", v, 32'h1111_1111);

    // R10 write lands within three slow edges (~23 bus cycles + margin)
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = 5'h08; bus_wdata = 32'h0BAD_0000;
    @(negedge clk); bus_sel = 0; bus_we = 0;
    repeat (25) @(negedge clk);
    rd(5'h08, v); chk("R10 landed in time", v, 32'h0BAD_0000);
    repeat (30) @(negedge clk);

    // R7/R8 alarm by counting
    wr(5'h00, 32'd10);
    wr(5'h08, 32'd12);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h10, 32'h0000_C898);
    chk("R8 no irq before match", {31'b0, irq}, 32'h0);
    repeat (320) @(negedge clk);
    chk("R8 irq at match", {31'b0, irq}, 32'h1);
    chk("R8 wake at match", {31'b0, wake}, 32'h1);
    wr(5'h10, 32'h0000_C890);
    rd(5'h14, v); chk("R7 flag set", v, 32'h0000_C008);

    // R9 write-one-to-clear
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, v); chk("R9 flag cleared, lifecycle kept", v, 32'h0000_C000);
    chk("R9 irq dropped", {31'b0, irq}, 32'h0);
    chk("R9 wake dropped", {31'b0, wake}, 32'h0);

    // R8 gating by enables
    wr(5'h10, 32'h0000_C810);
    wr(5'h00, 32'd20);
    wr(5'h08, 32'd20);
    chk("R8 wake only", {30'b0, irq, wake}, 32'h1);
    wr(5'h10, 32'h0000_C880);
    chk("R8 irq only", {30'b0, irq, wake}, 32'h2);
    wr(5'h10, 32'h0000_C800);
    wr(5'h14, 32'h0000_0008);

    // R7 random compare/seconds writes against the model
    wr(5'h08, 32'd1000);
    wr(5'h00, 32'd0);
    wr(5'h14, 32'hFFFF_FFFF);
    cur_s = 0; cur_a = 1000;
    for (int i = 0; i < 24; i++) begin
      int a, s;
      a = int'($urandom_range(0, 3));
      s = int'($urandom_range(0, 3));
      wr(5'h08, 32'(a), 30);
      wr(5'h00, 32'(s), 30);
      rd(5'h14, v);
      chk("R7 random flag", {31'b0, v[3]}, {31'b0, flag_model(cur_s, cur_a, a, s)});
      rd(5'h00, v); chk("R1 random seconds", v, 32'(s));
      wr(5'h14, 32'h0000_0008, 30);
      cur_s = s; cur_a = a;
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule